// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block keeps the tag and coherence state of one private direct-mapped cache on a bus where each transaction completes atomically. Every line is in one of four stable states: invalid, shared, exclusive or modified. The processor-side controller serves read and write requests. It answers hits at once. It raises a bus request for misses and for writes to shared lines, and holds the processor until the transaction is finished. The bus-side controller watches other caches' transactions. It drives the shared, dirty and wait response lines and downgrades or invalidates local lines.

Each controller has its own copy of the tag array, so the two sides can look up tags in parallel. Any tag change is written into both copies in the same cycle, and the processor side yields that cycle to the snooper. While a request waits for the bus, the controller remembers what it is waiting for: a read fill, an exclusive fill, or an upgrade of a shared line. If another cache wins an exclusive transaction to the same block during that wait, a pending upgrade becomes an exclusive fill. When a write has just obtained its block, snoops to that block are held off with the wait line until the write retires. This prevents the block from being stolen before it is used, which would cause livelock.

Bus commands use a 2-bit code: 0 none, 1 read, 2 exclusive read, 3 upgrade. Addresses are block addresses. The low `IDX_W` bits select the set and the rest form the tag.

Top module: `snoopCtl`

## Requirements
- R1: A read that finds the line shared, exclusive or modified, or a write that finds it modified, raises cpuDone in the same cycle the request is presented. No bus request is made.
- R2: A write to an exclusive line completes in the same cycle without bus traffic and turns the line modified. A later snooped read then sees dirty.
- R3: A read miss raises busReq with command 1 in the cycle after the request. cpuDone is high in the cycle busGnt is high. The line is installed exclusive if shrIn is low in that cycle, and shared otherwise; a later write to a shared line issues command 3.
- R4: A write miss requests command 2, and a write to a shared line requests command 3. cpuDone stays low in the grant cycle and is high in the cycle after it.
- R5: While a command-3 request waits for the bus, a snooped command 2 or 3 to the same block invalidates the local line. The pending request then changes to command 2.
- R6: A snooped read (command 1) hitting a modified line drives shrOut and dirtyOut high in that cycle and leaves the line shared.
- R7: A snooped read hitting a shared or exclusive line drives shrOut high and dirtyOut low. An exclusive line becomes shared.
- R8: A snooped command 2 or 3 hitting a valid line drives shrOut (plus dirtyOut if modified) and invalidates the line, so the next local read misses.
- R9: A snoop whose block is not held drives all response lines low and changes no line.
- R10: In the cycle a granted write retires (cpuDone high), a snoop of any command to that block raises waitOut, keeps shrOut and dirtyOut low and changes nothing. The same snoop presented in the next cycle is answered from the modified line.
- R11: In a cycle where the snooper writes a tag, the processor side neither completes nor starts a request, and the two sides never write tags in the same cycle.
- R12: After reset every line is invalid and cpuDone, busReq, shrOut, dirtyOut and waitOut are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuWr | input | 1 | Request is a write |
| cpuAddr | input | ADDR_W | Block address of the request |
| cpuDone | output | 1 | Request retires this cycle |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant; the transaction completes in this cycle |
| busCmd | output | 2 | Command of the requested transaction |
| busAddr | output | ADDR_W | Block address of the requested transaction |
| shrIn | input | 1 | OR of other caches' shared lines during our transaction |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 2 | Command of the snooped transaction |
| snpAddr | input | ADDR_W | Block address of the snooped transaction |
| shrOut | output | 1 | This cache holds the snooped block |
| dirtyOut | output | 1 | This cache holds the snooped block modified and supplies it |
| waitOut | output | 1 | Snoop not complete, retry |

## Verification
Hits and retiring writes are due in fixed cycles. Hits raise cpuDone in the request cycle. A read miss shows busReq one cycle after the request and cpuDone in the grant cycle. A write completes one cycle after its grant. Snoop responses belong to the cycle the snoop is presented, and their effect on the line is observed through the latency and bus command of the next local request. The bench drives inputs on the falling edge and samples one time unit later within the same cycle, then counts the cycles to cpuDone against these figures. A scoreboard queue receives each expected bus command and address before the request. A monitor pops it in the cycle that grant and request coincide, so an unexpected or missing transaction is reported.

// File: rtl/snoopPkg.sv
package snoopPkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} lineSt_e;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_UPG = 2'd3} busCmd_e;
  typedef enum logic [1:0] {CS_IDLE = 2'd0, CS_BUS = 2'd1, CS_WRITE = 2'd2} ctlSt_e;

  // strobes from control to the tag datapath
  typedef struct packed {
    logic    cpuWe;
    lineSt_e cpuSt;
    logic    snpWe;
    lineSt_e snpSt;
  } tagStb_t;
endpackage

// File: rtl/snoopTagDp.sv
module snoopTagDp
  import snoopPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  tagStb_t           tagStb,
  output lineSt_e           cpuLineSt,
  output lineSt_e           snpLineSt
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int COPIES = 2;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    lineSt_e          st;
  } tagEnt_t;

  // single shared write: snooper first, both copies together
  logic            wrEn;
  logic [IDX_W-1:0] wrIdx;
  tagEnt_t         wrEnt;

  always_comb begin
    wrEn  = 1'b0;
    wrIdx = cpuAddr[IDX_W-1:0];
    wrEnt = tagEnt_t'{tag: cpuAddr[ADDR_W-1:IDX_W], st: tagStb.cpuSt};
    if (tagStb.snpWe) begin
      wrEn  = 1'b1;
      wrIdx = snpAddr[IDX_W-1:0];
      wrEnt = tagEnt_t'{tag: snpAddr[ADDR_W-1:IDX_W], st: tagStb.snpSt};
    end else if (tagStb.cpuWe) begin
      wrEn = 1'b1;
    end
  end

  lineSt_e lookSt [COPIES];

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    tagEnt_t          mem [SETS];
    logic [ADDR_W-1:0] rdAddr;
    tagEnt_t          rdEnt;

    assign rdAddr = (c == 0) ? cpuAddr : snpAddr;
    assign rdEnt  = mem[rdAddr[IDX_W-1:0]];
    assign lookSt[c] = (rdEnt.tag == rdAddr[ADDR_W-1:IDX_W]) ? rdEnt.st : LS_I;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < SETS; i++) mem[i] <= '0;
      end else if (wrEn) begin
        mem[wrIdx] <= wrEnt;
      end
    end
  end

  assign cpuLineSt = lookSt[0];
  assign snpLineSt = lookSt[1];
endmodule

// File: rtl/snoopFsm.sv
module snoopFsm
  import snoopPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  lineSt_e           cpuLineSt,
  input  lineSt_e           snpLineSt,
  input  logic              busGnt,
  input  logic              shrIn,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              cpuDone,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic              shrOut,
  output logic              dirtyOut,
  output logic              waitOut,
  output tagStb_t           tagStb
);
  ctlSt_e            cState, nState;
  busCmd_e           pendKind, nKind;
  logic [ADDR_W-1:0] pendAddr;
  logic              latchAddr;

  logic snpHitPend, defer, snpAct, snpHit, snpExcl;

  // bus side
  always_comb begin
    snpHitPend = snpValid && (cState != CS_IDLE) && (snpAddr == pendAddr);
    defer      = snpHitPend && (cState == CS_WRITE);
    snpAct     = snpValid && !defer;
    snpHit     = (snpLineSt != LS_I);
    snpExcl    = (snpCmd == BC_RDX) || (snpCmd == BC_UPG);
    shrOut     = snpAct && snpHit;
    dirtyOut   = snpAct && (snpLineSt == LS_M);
    waitOut    = defer;
    tagStb.snpWe = 1'b0;
    tagStb.snpSt = LS_I;
    if (snpAct && snpHit) begin
      if (snpExcl) begin
        tagStb.snpWe = 1'b1;
        tagStb.snpSt = LS_I;
      end else if ((snpCmd == BC_RD) && ((snpLineSt == LS_E) || (snpLineSt == LS_M))) begin
        tagStb.snpWe = 1'b1;
        tagStb.snpSt = LS_S;
      end
    end
  end

  // processor side
  always_comb begin
    nState       = cState;
    nKind        = pendKind;
    latchAddr    = 1'b0;
    cpuDone      = 1'b0;
    tagStb.cpuWe = 1'b0;
    tagStb.cpuSt = LS_I;
    unique case (cState)
      CS_IDLE: begin
        if (cpuReq && !tagStb.snpWe) begin
          if ((!cpuWr && cpuLineSt != LS_I) || (cpuWr && cpuLineSt == LS_M)) begin
            cpuDone = 1'b1;
          end else if (cpuWr && cpuLineSt == LS_E) begin
            tagStb.cpuWe = 1'b1;
            tagStb.cpuSt = LS_M;
            cpuDone      = 1'b1;
          end else begin
            nState    = CS_BUS;
            latchAddr = 1'b1;
            if (!cpuWr)                nKind = BC_RD;
            else if (cpuLineSt == LS_S) nKind = BC_UPG;
            else                       nKind = BC_RDX;
          end
        end
      end
      CS_BUS: begin
        if (pendKind == BC_UPG && snpHitPend && snpExcl) nKind = BC_RDX;
        if (busGnt) begin
          tagStb.cpuWe = 1'b1;
          if (pendKind == BC_RD) begin
            tagStb.cpuSt = shrIn ? LS_S : LS_E;
            cpuDone      = 1'b1;
            nState       = CS_IDLE;
          end else begin
            tagStb.cpuSt = LS_M;
            nState       = CS_WRITE;
          end
        end
      end
      CS_WRITE: begin
        cpuDone = 1'b1;
        nState  = CS_IDLE;
      end
      default: nState = CS_IDLE;
    endcase
  end

  assign busReq  = (cState == CS_BUS);
  assign busCmd  = busReq ? pendKind : BC_NONE;
  assign busAddr = pendAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cState   <= CS_IDLE;
      pendKind <= BC_NONE;
      pendAddr <= '0;
    end else begin
      cState   <= nState;
      pendKind <= nKind;
      if (latchAddr) pendAddr <= cpuAddr;
    end
  end
endmodule

// File: rtl/snoopCtl.sv
module snoopCtl
  import snoopPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuDone,
  output logic              busReq,
  input  logic              busGnt,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              shrIn,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              shrOut,
  output logic              dirtyOut,
  output logic              waitOut
);
  tagStb_t tagStb;
  lineSt_e cpuLineSt, snpLineSt;

  snoopTagDp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .snpAddr(snpAddr),
    .tagStb(tagStb), .cpuLineSt(cpuLineSt), .snpLineSt(snpLineSt)
  );

  snoopFsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuLineSt(cpuLineSt), .snpLineSt(snpLineSt), .busGnt(busGnt), .shrIn(shrIn),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr), .cpuDone(cpuDone),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .shrOut(shrOut),
    .dirtyOut(dirtyOut), .waitOut(waitOut), .tagStb(tagStb)
  );
endmodule

// File: rtl/snoopCtl_chk.sv
module snoopCtl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuDone,
  input logic              busReq,
  input logic              busGnt,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              shrOut,
  input logic              dirtyOut,
  input logic              waitOut,
  input logic              cpuWeTap,
  input logic              snpWeTap
);
  AST_READ_DONE_AT_GNT: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busCmd == 2'd1) |-> cpuDone); // R3

  AST_WRITE_DONE_AFTER_GNT: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busCmd != 2'd1) |-> (!cpuDone ##1 cpuDone)); // R4

  AST_UPG_BECOMES_RDX: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && busCmd == 2'd3 && snpValid && snpAddr == busAddr &&
     (snpCmd == 2'd2 || snpCmd == 2'd3)) |=> (busReq && busCmd == 2'd2)); // R5

  AST_DIRTY_WITH_SHR: assert property (@(posedge clk) disable iff (!rstN)
    dirtyOut |-> shrOut); // R6

  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    waitOut |-> (!shrOut && !dirtyOut && cpuDone)); // R10

  AST_ONE_TAG_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWeTap && snpWeTap)); // R11
endmodule

bind snoopCtl snoopCtl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuDone(cpuDone), .busReq(busReq), .busGnt(busGnt),
  .busCmd(busCmd), .busAddr(busAddr), .snpValid(snpValid), .snpCmd(snpCmd),
  .snpAddr(snpAddr), .shrOut(shrOut), .dirtyOut(dirtyOut), .waitOut(waitOut),
  .cpuWeTap(tagStb.cpuWe), .snpWeTap(tagStb.snpWe)
);

// File: tb/snoopCtl_tb.sv
module snoopCtl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [1:0] CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_UPG = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWr = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic cpuDone, busReq, busGnt;
  logic [1:0] busCmd;
  logic [AW-1:0] busAddr;
  logic shrIn = 1'b0;
  logic gntEn = 1'b1;
  logic snpValid = 1'b0;
  logic [1:0] snpCmd = 2'd0;
  logic [AW-1:0] snpAddr = '0;
  logic shrOut, dirtyOut, waitOut;

  int nChecks = 0;
  int nFail = 0;
  bit doneFlag = 1'b0;
  logic [AW+1:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign busGnt = busReq && gntEn;

  snoopCtl u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuDone(cpuDone), .busReq(busReq), .busGnt(busGnt), .busCmd(busCmd),
    .busAddr(busAddr), .shrIn(shrIn), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpAddr(snpAddr), .shrOut(shrOut), .dirtyOut(dirtyOut), .waitOut(waitOut)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic busExp(input logic [1:0] cmd, input logic [AW-1:0] a);
    expQ.push_back({cmd, a});
  endtask

  // monitor: compares each completed bus transaction with the scoreboard
  always @(negedge clk) begin
    #2;
    if (rstN && busReq && busGnt) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R1", "unexpected bus cmd", int'(busCmd), 0);
      end else begin
        logic [AW+1:0] e;
        e = expQ.pop_front();
        chk({busCmd, busAddr} == e, "R3", "bus cmd/addr", int'({busCmd, busAddr}), int'(e));
      end
    end
  end

  task automatic cpuOp(input bit wr, input logic [AW-1:0] a, input int expCyc, input string req);
    int n = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = wr; cpuAddr = a;
    #1;
    while (!cpuDone && n < 40) begin
      @(negedge clk); #1; n++;
    end
    chk(n == expCyc, req, "cycles to cpuDone", n, expCyc);
    @(negedge clk);
    cpuReq = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a,
                       input bit eS, input bit eD, input bit eW, input string req);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = a;
    #1;
    chk({shrOut, dirtyOut, waitOut} == {eS, eD, eW}, req, "shr/dirty/wait",
        int'({shrOut, dirtyOut, waitOut}), int'({eS, eD, eW}));
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  localparam logic [AW-1:0] A = 16'h0011, B = 16'h0022, C = 16'h0033, D = 16'h0044;
  localparam logic [AW-1:0] E2 = 16'h0055, F = 16'h0019, G = 16'h0066;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk({cpuDone, busReq, shrOut, dirtyOut, waitOut} == 5'b0, "R12", "outputs after reset",
        int'({cpuDone, busReq, shrOut, dirtyOut, waitOut}), 0);
    snoop(CMD_RD, A, 0, 0, 0, "R12");

    // R3: read miss, no sharer -> exclusive
    busExp(CMD_RD, A); cpuOp(0, A, 1, "R3");
    cpuOp(1, A, 0, "R2");                 // silent E->M
    snoop(CMD_RD, A, 1, 1, 0, "R6");      // M supplies, -> S
    busExp(CMD_UPG, A); cpuOp(1, A, 2, "R6"); // S needs upgrade
    cpuOp(0, A, 0, "R1");
    cpuOp(1, A, 0, "R1");

    // R3: read miss with sharer -> shared
    shrIn = 1'b1; busExp(CMD_RD, B); cpuOp(0, B, 1, "R3"); shrIn = 1'b0;
    snoop(CMD_RD, B, 1, 0, 0, "R7");
    cpuOp(0, B, 0, "R1");
    busExp(CMD_UPG, B); cpuOp(1, B, 2, "R4");

    // R7: E downgraded by snooped read; R8 invalidation
    busExp(CMD_RD, C); cpuOp(0, C, 1, "R3");
    snoop(CMD_RD, C, 1, 0, 0, "R7");
    busExp(CMD_UPG, C); cpuOp(1, C, 2, "R7");
    snoop(CMD_RDX, C, 1, 1, 0, "R8");
    busExp(CMD_RD, C); cpuOp(0, C, 1, "R8");

    // R9: same set, other tag
    snoop(CMD_RDX, F, 0, 0, 0, "R9");
    cpuOp(0, A, 0, "R9");

    // R4: write miss
    busExp(CMD_RDX, E2); cpuOp(1, E2, 2, "R4");

    // R5: pending upgrade overtaken by remote upgrade
    shrIn = 1'b1; busExp(CMD_RD, D); cpuOp(0, D, 1, "R3"); shrIn = 1'b0;
    gntEn = 1'b0;
    @(negedge clk); cpuReq = 1'b1; cpuWr = 1'b1; cpuAddr = D;
    @(negedge clk); snpValid = 1'b1; snpCmd = CMD_UPG; snpAddr = D;
    #1;
    chk(busReq && busCmd == CMD_UPG, "R5", "pending upgrade cmd", int'(busCmd), int'(CMD_UPG));
    chk(shrOut == 1'b1, "R5", "shared line hit", int'(shrOut), 1);
    @(negedge clk); snpValid = 1'b0; gntEn = 1'b1; busExp(CMD_RDX, D);
    #1;
    chk(busReq && busCmd == CMD_RDX && !cpuDone, "R5", "converted cmd", int'(busCmd), int'(CMD_RDX));
    @(negedge clk); #1;
    chk(cpuDone == 1'b1, "R4", "done after grant", int'(cpuDone), 1);
    @(negedge clk); cpuReq = 1'b0;
    cpuOp(0, D, 0, "R5");
    snoop(CMD_RD, D, 1, 1, 0, "R5");

    // R10: snoop deferred while write retires
    busExp(CMD_RDX, G);
    @(negedge clk); cpuReq = 1'b1; cpuWr = 1'b1; cpuAddr = G;
    #1; chk(busReq == 1'b0, "R4", "busReq in request cycle", int'(busReq), 0);
    @(negedge clk); #1;
    chk(busReq && !cpuDone, "R4", "grant cycle done low", int'(cpuDone), 0);
    @(negedge clk); snpValid = 1'b1; snpCmd = CMD_RDX; snpAddr = G;
    #1;
    chk({cpuDone, waitOut, shrOut, dirtyOut} == 4'b1100, "R10", "deferred snoop",
        int'({cpuDone, waitOut, shrOut, dirtyOut}), 12);
    @(negedge clk); cpuReq = 1'b0;
    #1;
    chk({waitOut, shrOut, dirtyOut} == 3'b011, "R10", "retried snoop",
        int'({waitOut, shrOut, dirtyOut}), 3);
    @(negedge clk); snpValid = 1'b0;
    busExp(CMD_RD, G); cpuOp(0, G, 1, "R10");

    // R11: snoop tag write stalls a processor hit
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = 1'b0; cpuAddr = A;
    snpValid = 1'b1; snpCmd = CMD_UPG; snpAddr = C;
    #1;
    chk(!cpuDone && !busReq && shrOut, "R11", "cpu stalled in snoop update",
        int'({cpuDone, busReq, shrOut}), 1);
    @(negedge clk); snpValid = 1'b0;
    #1;
    chk(cpuDone == 1'b1, "R11", "hit completes after stall", int'(cpuDone), 1);
    @(negedge clk); cpuReq = 1'b0;
    busExp(CMD_RD, C); cpuOp(0, C, 1, "R8");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R3", "scoreboard drained", expQ.size(), 0);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog R12 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule